// File: doc/BRIEF.md
# Bus-Master DMA Address/Count Engine

This block drives block transfers between two local FIFOs and a host bus. It keeps one address and one byte count for each direction. A read moves data from the host into the host-to-local FIFO. A write moves data from the local-to-host FIFO out to the host. For every word the block issues a single-word request on a simple request/acknowledge bus-master port. When the word is acknowledged, the block advances the address by four and lowers the count by four.

A configuration input decides which side may load the four registers: the local register port or the host register port. The completion interrupt goes to the same side. A byte-wide boot configuration blocks locally programmed mastering. A count-ignore input lets a direction keep moving words for as long as it is enabled, whatever its count. Each direction has its own enable. Clearing an enable pauses that direction without losing its address or count.

Top module: `bm_engine`

## Requirements
- R1: After reset both addresses and both counts are zero, `bm_req` is low, both completion flags are clear and both interrupts are low.
- R2: A register write uses the select codes 0 = read address, 1 = write address, 2 = read count and 3 = write count. The local port's writes take effect only while `host_own` is 0, and the host port's writes only while `host_own` is 1. A write from the other port leaves every register unchanged.
- R3: A read request (`bm_dir` = 0) starts only if `rd_enable` is high, `h2l_full` is low and the read count is nonzero or `cnt_ignore` is high. A write request (`bm_dir` = 1) starts only under the same rules using `wr_enable`, `l2h_empty` and the write count.
- R4: Once raised, `bm_req` stays high with `bm_dir` and `bm_addr` unchanged until a cycle with `bm_ack` high. It is low in the next cycle. `bm_addr` equals the direction's address register at the cycle the request was granted.
- R5: Each acknowledged word adds 4 to its direction's address and subtracts 4 from its count. A count of 4 or less becomes 0.
- R6: With `cnt_ignore` low, a direction whose count is zero issues no request. With `cnt_ignore` high, words continue while the direction is enabled, and no completion flag is set.
- R7: `done[0]` (read) or `done[1]` (write) sets on the acknowledge that takes a nonzero count to zero while `cnt_ignore` is low.
- R8: The completion flags are sticky. A 1 in a bit of `done_clr` clears that flag, and a set in the same cycle wins over the clear.
- R9: `irq_host` is high exactly when a flag is set and `host_own` is 1. `irq_local` is high exactly when a flag is set and `host_own` is 0.
- R10: While `host_own` is 0 and `byte_boot` is 1, no request starts.
- R11: When both directions are eligible in the same idle cycle, the direction not granted most recently wins. After reset, read counts as the opposite of the last grant, so it goes first.
- R12: Dropping an enable while a word is pending does not withdraw it. After that word, the direction stops. Its address and count are kept, and it resumes from them once re-enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_own | input | 1 | 1: host side owns the registers and the interrupt; 0: local side |
| byte_boot | input | 1 | Byte-wide boot device selected; blocks locally programmed mastering |
| loc_we | input | 1 | Local register write strobe |
| loc_sel | input | 2 | Local register select |
| loc_wdata | input | AW | Local write data |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Host register select |
| host_wdata | input | AW | Host write data |
| rd_enable | input | 1 | Enable for master reads |
| wr_enable | input | 1 | Enable for master writes |
| cnt_ignore | input | 1 | Ignore byte counts |
| h2l_full | input | 1 | Host-to-local FIFO full |
| l2h_empty | input | 1 | Local-to-host FIFO empty |
| done_clr | input | 2 | Write-1-to-clear for the completion flags |
| bm_req | output | 1 | Word transfer request |
| bm_dir | output | 1 | 0 read, 1 write |
| bm_addr | output | AW | Word address of the request |
| bm_ack | input | 1 | Word acknowledged |
| rd_addr | output | AW | Current read address |
| wr_addr | output | AW | Current write address |
| rd_cnt | output | CW | Remaining read bytes |
| wr_cnt | output | CW | Remaining write bytes |
| done | output | 2 | Completion flags {write, read} |
| irq_host | output | 1 | Host-side interrupt |
| irq_local | output | 1 | Local-side interrupt |

## Verification
The checker watches on every cycle that a pending request holds still until acknowledged and drops afterwards. It also checks that a read starts only with its enable set and room in the FIFO, that a blocked boot configuration starts nothing, that the address and count step exactly four bytes per acknowledge, that the flags stay sticky, and that the two interrupts never coincide. The following only show up in the bench's scenarios:
- the rule that writes from the non-owning port are ignored;
- count saturation on a ragged last word;
- alternating arbitration;
- pause and resume from kept state;
- count-ignore running past zero.

// File: rtl/bm_pkg.sv
package bm_pkg;

    typedef enum logic [1:0] {
        SEL_RADDR = 2'd0,
        SEL_WADDR = 2'd1,
        SEL_RCNT  = 2'd2,
        SEL_WCNT  = 2'd3
    } reg_sel_e;

    localparam logic DIR_RD = 1'b0;
    localparam logic DIR_WR = 1'b1;

    localparam int WORD_BYTES = 4;

endpackage

// File: rtl/bm_chan.sv
module bm_chan #(
    parameter int AW   = 32,
    parameter int CW   = 16,
    parameter int STEP = 4
) (
    input  logic [AW-1:0] addr_q,
    input  logic [CW-1:0] cnt_q,
    input  logic          addr_we,
    input  logic          cnt_we,
    input  logic [AW-1:0] wdata,
    input  logic          step,
    input  logic          cnt_ignore,
    output logic [AW-1:0] addr_d,
    output logic [CW-1:0] cnt_d,
    output logic          ready,
    output logic          finish
);
    localparam logic [AW-1:0] STEP_A = AW'(STEP);
    localparam logic [CW-1:0] STEP_C = CW'(STEP);

    logic last_word;

    always_comb begin
        last_word = (cnt_q != '0) && (cnt_q <= STEP_C);
        ready     = cnt_ignore || (cnt_q != '0);
        finish    = step && !cnt_ignore && last_word;

        if (addr_we)   addr_d = wdata;
        else if (step) addr_d = addr_q + STEP_A;
        else           addr_d = addr_q;

        if (cnt_we)              cnt_d = wdata[CW-1:0];
        else if (step) begin
            if (cnt_q <= STEP_C) cnt_d = '0;
            else                 cnt_d = cnt_q - STEP_C;
        end
        else                     cnt_d = cnt_q;
    end
endmodule

// File: rtl/bm_arb.sv
module bm_arb (
    input  logic [1:0] elig,
    input  logic       last_dir,
    output logic       gnt_vld,
    output logic       gnt_dir
);
    always_comb begin
        gnt_vld = |elig;
        if (elig == 2'b11) gnt_dir = ~last_dir;
        else               gnt_dir = elig[1];
    end
endmodule

// File: rtl/bm_engine.sv
module bm_engine
    import bm_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_own,
    input  logic          byte_boot,
    input  logic          loc_we,
    input  logic [1:0]    loc_sel,
    input  logic [AW-1:0] loc_wdata,
    input  logic          host_we,
    input  logic [1:0]    host_sel,
    input  logic [AW-1:0] host_wdata,
    input  logic          rd_enable,
    input  logic          wr_enable,
    input  logic          cnt_ignore,
    input  logic          h2l_full,
    input  logic          l2h_empty,
    input  logic [1:0]    done_clr,
    output logic          bm_req,
    output logic          bm_dir,
    output logic [AW-1:0] bm_addr,
    input  logic          bm_ack,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] wr_addr,
    output logic [CW-1:0] rd_cnt,
    output logic [CW-1:0] wr_cnt,
    output logic [1:0]    done,
    output logic          irq_host,
    output logic          irq_local
);
    localparam int NDIR = 2;

    typedef struct packed {
        logic [NDIR-1:0][AW-1:0] addr;
        logic [NDIR-1:0][CW-1:0] cnt;
        logic                    req;
        logic                    dir;
        logic [AW-1:0]           req_addr;
        logic                    last_dir;
        logic [NDIR-1:0]         done;
    } state_t;

    state_t q, d;

    // Write port selected by ownership
    logic          wr_acc;
    logic [1:0]    wr_sel;
    logic [AW-1:0] wr_dat;
    logic          allow;

    assign wr_acc = host_own ? host_we    : loc_we;
    assign wr_sel = host_own ? host_sel   : loc_sel;
    assign wr_dat = host_own ? host_wdata : loc_wdata;
    assign allow  = host_own | ~byte_boot;

    logic [NDIR-1:0]         step, ready, finish, elig;
    logic [NDIR-1:0][AW-1:0] addr_nx;
    logic [NDIR-1:0][CW-1:0] cnt_nx;
    logic [NDIR-1:0]         room;
    logic [NDIR-1:0]         en;

    assign room = {~l2h_empty, ~h2l_full};
    assign en   = {wr_enable, rd_enable};

    for (genvar g = 0; g < NDIR; g++) begin : g_chan
        localparam reg_sel_e ASEL = (g == 0) ? SEL_RADDR : SEL_WADDR;
        localparam reg_sel_e CSEL = (g == 0) ? SEL_RCNT  : SEL_WCNT;

        assign step[g] = q.req && bm_ack && (q.dir == 1'(g));
        assign elig[g] = allow && !q.req && en[g] && ready[g] && room[g];

        bm_chan #(.AW(AW), .CW(CW), .STEP(WORD_BYTES)) u_chan (
            .addr_q     (q.addr[g]),
            .cnt_q      (q.cnt[g]),
            .addr_we    (wr_acc && (wr_sel == ASEL)),
            .cnt_we     (wr_acc && (wr_sel == CSEL)),
            .wdata      (wr_dat),
            .step       (step[g]),
            .cnt_ignore (cnt_ignore),
            .addr_d     (addr_nx[g]),
            .cnt_d      (cnt_nx[g]),
            .ready      (ready[g]),
            .finish     (finish[g])
        );
    end

    logic gnt_vld, gnt_dir;

    bm_arb u_arb (
        .elig     (elig),
        .last_dir (q.last_dir),
        .gnt_vld  (gnt_vld),
        .gnt_dir  (gnt_dir)
    );

    always_comb begin
        d      = q;
        d.addr = addr_nx;
        d.cnt  = cnt_nx;
        if (q.req) begin
            if (bm_ack) d.req = 1'b0;
        end else if (gnt_vld) begin
            d.req      = 1'b1;
            d.dir      = gnt_dir;
            d.last_dir = gnt_dir;
            d.req_addr = q.addr[gnt_dir];
        end
        d.done = (q.done & ~done_clr) | finish;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.last_dir <= DIR_WR;
        end else begin
            q <= d;
        end
    end

    assign bm_req    = q.req;
    assign bm_dir    = q.dir;
    assign bm_addr   = q.req_addr;
    assign rd_addr   = q.addr[0];
    assign wr_addr   = q.addr[1];
    assign rd_cnt    = q.cnt[0];
    assign wr_cnt    = q.cnt[1];
    assign done      = q.done;
    assign irq_host  = host_own & (|q.done);
    assign irq_local = ~host_own & (|q.done);

endmodule

// File: rtl/bm_engine_chk.sv
module bm_engine_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_own,
    input logic          byte_boot,
    input logic          loc_we,
    input logic          host_we,
    input logic          rd_enable,
    input logic          h2l_full,
    input logic [1:0]    done_clr,
    input logic          bm_req,
    input logic          bm_dir,
    input logic [AW-1:0] bm_addr,
    input logic          bm_ack,
    input logic [AW-1:0] rd_addr,
    input logic [CW-1:0] rd_cnt,
    input logic [1:0]    done,
    input logic          irq_host,
    input logic          irq_local
);
    localparam logic [AW-1:0] FOUR_A = AW'(4);
    localparam logic [CW-1:0] FOUR_C = CW'(4);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bm_req && !bm_ack |=> bm_req && $stable(bm_dir) && $stable(bm_addr)); // R4

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        bm_req && bm_ack |=> !bm_req); // R4

    AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bm_req) && !bm_dir |-> $past(rd_enable) && !$past(h2l_full)); // R3

    AST_BOOT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !bm_req && !host_own && byte_boot |=> !bm_req); // R10

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        bm_req && bm_ack && !bm_dir && !loc_we && !host_we
        |=> rd_addr == $past(rd_addr) + FOUR_A); // R5

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        bm_req && bm_ack && !bm_dir && !loc_we && !host_we && rd_cnt > FOUR_C
        |=> rd_cnt == $past(rd_cnt) - FOUR_C); // R5

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done[0] && !done_clr[0] |=> done[0]); // R8

    AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_host && irq_local)); // R9

endmodule

bind bm_engine bm_engine_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_own  (host_own),
    .byte_boot (byte_boot),
    .loc_we    (loc_we),
    .host_we   (host_we),
    .rd_enable (rd_enable),
    .h2l_full  (h2l_full),
    .done_clr  (done_clr),
    .bm_req    (bm_req),
    .bm_dir    (bm_dir),
    .bm_addr   (bm_addr),
    .bm_ack    (bm_ack),
    .rd_addr   (rd_addr),
    .rd_cnt    (rd_cnt),
    .done      (done),
    .irq_host  (irq_host),
    .irq_local (irq_local)
);

// File: tb/bm_engine_test.sv
module bm_engine_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_own = 1'b0, byte_boot = 1'b0;
    logic        loc_we = 1'b0, host_we = 1'b0;
    logic [1:0]  loc_sel = '0, host_sel = '0;
    logic [31:0] loc_wdata = '0, host_wdata = '0;
    logic        rd_enable = 1'b0, wr_enable = 1'b0, cnt_ignore = 1'b0;
    logic        h2l_full = 1'b0, l2h_empty = 1'b0;
    logic [1:0]  done_clr = '0;
    logic        bm_ack = 1'b0;
    logic        bm_req, bm_dir, irq_host, irq_local;
    logic [31:0] bm_addr, rd_addr, wr_addr;
    logic [15:0] rd_cnt, wr_cnt;
    logic [1:0]  done;

    logic        ack_gate = 1'b0, stall_en = 1'b0;
    logic [7:0]  lfsr = 8'h5A;

    int total = 0, bad = 0, cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bm_engine #(.AW(32), .CW(16)) uut (
        .clk(clk), .rst_n(rst_n), .host_own(host_own), .byte_boot(byte_boot),
        .loc_we(loc_we), .loc_sel(loc_sel), .loc_wdata(loc_wdata),
        .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
        .rd_enable(rd_enable), .wr_enable(wr_enable), .cnt_ignore(cnt_ignore),
        .h2l_full(h2l_full), .l2h_empty(l2h_empty), .done_clr(done_clr),
        .bm_req(bm_req), .bm_dir(bm_dir), .bm_addr(bm_addr), .bm_ack(bm_ack),
        .rd_addr(rd_addr), .wr_addr(wr_addr), .rd_cnt(rd_cnt), .wr_cnt(wr_cnt),
        .done(done), .irq_host(irq_host), .irq_local(irq_local)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    logic [31:0] m_addr [2] = '{32'd0, 32'd0};
    logic [15:0] m_cnt  [2] = '{16'd0, 16'd0};
    logic        m_req = 1'b0, m_dir = 1'b0, m_last = 1'b1;
    logic [31:0] m_raddr = '0;
    logic [1:0]  m_done = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_addr[0] = 0; m_addr[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
            m_req = 0; m_dir = 0; m_last = 1; m_raddr = 0; m_done = 0;
        end else begin
            logic        acc, ok, pick;
            logic [1:0]  sel, fin, el;
            logic [31:0] dat;
            logic [31:0] na [2];
            logic [15:0] nc [2];
            acc = host_own ? host_we : loc_we;
            sel = host_own ? host_sel : loc_sel;
            dat = host_own ? host_wdata : loc_wdata;
            ok  = host_own || !byte_boot;
            el[0] = ok && !m_req && rd_enable && !h2l_full && (cnt_ignore || m_cnt[0] != 0);
            el[1] = ok && !m_req && wr_enable && !l2h_empty && (cnt_ignore || m_cnt[1] != 0);
            for (int i = 0; i < 2; i++) begin
                logic stp;
                stp    = m_req && bm_ack && (m_dir == i[0]);
                fin[i] = stp && !cnt_ignore && m_cnt[i] != 0 && m_cnt[i] <= 4;
                if (acc && sel == 2'(i))       na[i] = dat;
                else if (stp)                   na[i] = m_addr[i] + 4;
                else                            na[i] = m_addr[i];
                if (acc && sel == 2'(i + 2))   nc[i] = dat[15:0];
                else if (stp)                   nc[i] = (m_cnt[i] <= 4) ? 16'd0 : m_cnt[i] - 16'd4;
                else                            nc[i] = m_cnt[i];
            end
            if (m_req) begin
                if (bm_ack) m_req = 0;
            end else if (el != 0) begin
                pick    = (el == 2'b11) ? !m_last : el[1];
                m_req   = 1;
                m_dir   = pick;
                m_last  = pick;
                m_raddr = m_addr[pick];
            end
            m_done = (m_done & ~done_clr) | fin;
            for (int i = 0; i < 2; i++) begin
                m_addr[i] = na[i];
                m_cnt[i]  = nc[i];
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        chk("R4", "bm_req", bm_req, m_req);
        if (m_req) begin
            chk("R11", "bm_dir", bm_dir, m_dir);
            chk("R4", "bm_addr", bm_addr, m_raddr);
        end
        chk("R5", "rd_addr", rd_addr, m_addr[0]);
        chk("R5", "wr_addr", wr_addr, m_addr[1]);
        chk("R5", "rd_cnt", rd_cnt, m_cnt[0]);
        chk("R5", "wr_cnt", wr_cnt, m_cnt[1]);
        chk("R7", "done", done, m_done);
        chk("R9", "irq_host", irq_host, host_own && m_done != 0);
        chk("R9", "irq_local", irq_local, !host_own && m_done != 0);
    end

    // Bus responder
    always begin
        @(negedge clk);
        #2;
        lfsr   = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        bm_ack = bm_req && ack_gate && !(stall_en && lfsr[0]);
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            total++; bad++;
            $display("FAIL R1 watchdog actual=%0d expected<=50000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wreg(input bit from_host, input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk); #1;
        if (from_host) begin host_we = 1; host_sel = sel; host_wdata = val; end
        else           begin loc_we = 1; loc_sel = sel; loc_wdata = val; end
        @(negedge clk); #1;
        host_we = 0; loc_we = 0;
    endtask

    task automatic wait_flag(input int b, input string tag);
        for (int k = 0; k < 300 && !done[b]; k++) idle(1);
        chk(tag, "completion reached", done[b], 1'b1);
    endtask

    task automatic clear_flags;
        @(negedge clk); #1; done_clr = 2'b11;
        @(negedge clk); #1; done_clr = 2'b00;
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        // R1 reset state
        chk("R1", "rd_addr", rd_addr, 0);
        chk("R1", "wr_cnt", wr_cnt, 0);
        chk("R1", "bm_req", bm_req, 0);
        chk("R1", "irq", {irq_host, irq_local}, 0);

        // Local ownership, read direction
        wreg(0, 2'd0, 32'h1000);
        wreg(0, 2'd2, 32'd12);
        wreg(1, 2'd0, 32'hDEAD0000);
        chk("R2", "host write ignored", rd_addr, 32'h1000);
        ack_gate = 1; stall_en = 1; rd_enable = 1;
        wait_flag(0, "R7");
        chk("R5", "rd_addr end", rd_addr, 32'h100C);
        chk("R6", "rd_cnt end", rd_cnt, 0);
        chk("R9", "irq_local", irq_local, 1);
        idle(10);
        chk("R6", "stopped at zero", bm_req, 0);
        clear_flags();
        chk("R8", "cleared", done, 0);
        chk("R9", "irq_local cleared", irq_local, 0);

        // Write direction, FIFO gating, ragged count
        rd_enable = 0;
        l2h_empty = 1;
        wreg(0, 2'd1, 32'h2000);
        wreg(0, 2'd3, 32'd10);
        wr_enable = 1;
        idle(8);
        chk("R3", "no write while empty", bm_req, 0);
        l2h_empty = 0;
        wait_flag(1, "R7");
        chk("R5", "wr_addr end", wr_addr, 32'h200C);
        chk("R5", "wr_cnt saturated", wr_cnt, 0);
        wr_enable = 0;
        clear_flags();

        // Arbitration
        wreg(0, 2'd0, 32'h3000);
        wreg(0, 2'd1, 32'h4000);
        wreg(0, 2'd2, 32'd8);
        wreg(0, 2'd3, 32'd8);
        stall_en = 0;
        idle(1);
        rd_enable = 1; wr_enable = 1;
        @(negedge clk);
        chk("R11", "first grant read", {bm_req, bm_dir}, 2'b10);
        @(negedge clk);
        @(negedge clk);
        chk("R11", "second grant write", {bm_req, bm_dir}, 2'b11);
        #1;
        wait_flag(0, "R7");
        wait_flag(1, "R7");
        chk("R5", "arb rd_addr", rd_addr, 32'h3008);
        chk("R5", "arb wr_addr", wr_addr, 32'h4008);
        rd_enable = 0; wr_enable = 0;
        clear_flags();

        // Pause and resume
        ack_gate = 0;
        wreg(0, 2'd0, 32'h5000);
        wreg(0, 2'd2, 32'd32);
        rd_enable = 1;
        idle(3);
        rd_enable = 0;
        idle(3);
        chk("R12", "pending word kept", bm_req, 1);
        ack_gate = 1;
        idle(5);
        chk("R12", "paused", bm_req, 0);
        chk("R12", "addr kept", rd_addr, 32'h5004);
        chk("R12", "cnt kept", rd_cnt, 28);
        rd_enable = 1;
        wait_flag(0, "R12");
        chk("R12", "resumed to end", rd_addr, 32'h5020);
        rd_enable = 0;
        clear_flags();

        // Count-ignore
        cnt_ignore = 1; stall_en = 1;
        wreg(0, 2'd0, 32'h6000);
        wreg(0, 2'd2, 32'd0);
        rd_enable = 1;
        idle(30);
        chk("R6", "no flag with ignore", done[0], 0);
        chk("R6", "moved with ignore", rd_addr != 32'h6000, 1);
        rd_enable = 0;
        idle(12);
        cnt_ignore = 0;
        idle(2);
        chk("R6", "idle after ignore", bm_req, 0);

        // Boot block and host ownership
        byte_boot = 1;
        wreg(0, 2'd0, 32'h7000);
        wreg(0, 2'd2, 32'd8);
        rd_enable = 1;
        idle(10);
        chk("R10", "no start", bm_req, 0);
        chk("R10", "count untouched", rd_cnt, 8);
        rd_enable = 0;
        host_own = 1;
        wreg(0, 2'd0, 32'h9999);
        chk("R2", "local write ignored", rd_addr, 32'h7000);
        wreg(1, 2'd0, 32'h8000);
        chk("R2", "host write taken", rd_addr, 32'h8000);
        rd_enable = 1;
        wait_flag(0, "R7");
        chk("R9", "irq_host", irq_host, 1);
        chk("R9", "irq_local low", irq_local, 0);
        idle(5);
        chk("R8", "sticky", done[0], 1);
        clear_flags();
        chk("R8", "host clear", done, 0);

        idle(3);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule